// File: doc/BRIEF.md
# Fan Tachometer Capture Timer

This block times the interval between pulses from a cooling fan's tachometer output. It has two measurement channels, each with a 16-bit down-counter, a capture register and a compare register. Both counters take their count enable from one shared prescaler. Software loads a counter, writes a compare value that defines the longest interval it will accept, and starts the counter's clock.

On the first rising edge from the selected tachometer pin, the counter value is copied into the capture register and the measurement stops. If the counter reaches the compare value first, a timeout flag is raised and the measurement stops. With two pulses per fan revolution, software converts the number of ticks elapsed from 0xFFFF into a rotation rate.

All registers sit behind a simple single-cycle bus. Halfword registers take the full 16-bit write data and byte registers take the low 8 bits. Reads are combinational and zero-extended. The interrupt line is raised by any pending flag whose enable bit is set.

Top module: `tach_timer`

## Requirements
- R1: After reset, both counters and both capture registers read 0xFFFF. The status register, clock control and interrupt enable read 0, and irq_o is low.
- R2: Register offsets are: prescaler 0x08, mode 0x0C, interrupt enable 0x12, compare config 0x18, pin select 0x1A (channel A) and 0x1C (channel B), compare A 0x14 and compare B 0x16 (halfword). Each of these reads back what was last written.
- R3: Clock control bit 0 runs counter A (offset 0x00) and bit 3 runs counter B (offset 0x06). Writing 0 to a bit stops that counter, which then holds its value. A running counter decrements once every (prescaler+1) clock cycles, counted from the write that starts it.
- R4: A tachometer rising edge is seen through a two-flop synchroniser. When it is seen on a running, enabled channel, the counter value is copied into that channel's capture register (A 0x02, B 0x04), status bit 0 (A) or bit 1 (B) is set, and the channel's clock control bit clears. The counter and capture register then read equal. If the pin rises between clock edges j and j+1 after the start edge, the capture value is 0xFFFF − floor((j+2)/(prescaler+1)).
- R5: When compare-enable is on (compare config bit 2 for A, bit 6 for B) and a running, enabled counter equals its compare value, status bit 4 (A) or bit 5 (B) is set. The counter then stops and holds the compare value.
- R6: If a capture and a timeout fall in the same cycle on one channel, the capture wins. Only the capture flag is set, and the capture register receives the compare value.
- R7: A running counter that decrements from 0 wraps to 0xFFFF, sets status bit 2 (A) or bit 3 (B) and keeps running.
- R8: The status register is at 0x0E and the clear register is at 0x10. Writing a 1 to a bit of the clear register clears that status bit. Writing a 0 leaves the status bit unchanged.
- R9: irq_o is high exactly when some status bit is set and its bit in the interrupt enable register is set.
- R10: A write to a counter is ignored while that counter runs. A write to a stopped counter loads it.
- R11: A channel produces no events while its mode bit is clear (mode bit 2 for A, bit 5 for B), though its counter still counts.
- R12: A pin select value of 0 connects a channel to its own pin (tach_i[0] for A, tach_i[1] for B). A value of 1 connects it to the other pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | 16 | Write data (low byte for byte registers) |
| rdata_o | output | 16 | Read data for addr_i, zero-extended |
| tach_i | input | 2 | Tachometer pulse inputs, asynchronous |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A capture and a timeout can both occur in one cycle on a single channel. This happens when the synchronised tachometer edge is seen in the same cycle in which the counter first equals its compare value. The bench provokes it with a prescaler of 1 (register value 0) and a compare value 20 ticks below 0xFFFF, and raises the pin exactly 18 edges after the start edge. The result is judged by three observations: the status register must show only the capture flag, the capture register must hold the compare value, and the clock control bit must be clear. Randomised captures around this case check the exact capture count over random prescaler values and edge times.

// File: rtl/tach_pkg.sv
`timescale 1ns/1ps
package tach_pkg;
  parameter int CNT_W = 16;
  parameter int PRE_W = 8;
  parameter int AW    = 5;
  parameter int NCH   = 2;
  parameter int NPEND = 6;

  localparam logic [AW-1:0] OFS_CNT_A  = 5'h00;
  localparam logic [AW-1:0] OFS_CAP_A  = 5'h02;
  localparam logic [AW-1:0] OFS_CAP_B  = 5'h04;
  localparam logic [AW-1:0] OFS_CNT_B  = 5'h06;
  localparam logic [AW-1:0] OFS_PRE    = 5'h08;
  localparam logic [AW-1:0] OFS_RUN    = 5'h0A;
  localparam logic [AW-1:0] OFS_MODE   = 5'h0C;
  localparam logic [AW-1:0] OFS_STAT   = 5'h0E;
  localparam logic [AW-1:0] OFS_CLR    = 5'h10;
  localparam logic [AW-1:0] OFS_IEN    = 5'h12;
  localparam logic [AW-1:0] OFS_CMP_A  = 5'h14;
  localparam logic [AW-1:0] OFS_CMP_B  = 5'h16;
  localparam logic [AW-1:0] OFS_CCFG   = 5'h18;
  localparam logic [AW-1:0] OFS_SEL_A  = 5'h1A;
  localparam logic [AW-1:0] OFS_SEL_B  = 5'h1C;

  // per-channel control bit positions
  localparam int RUN_BIT  [NCH] = '{0, 3};
  localparam int MODE_BIT [NCH] = '{2, 5};
  localparam int CCFG_BIT [NCH] = '{2, 6};
endpackage

// File: rtl/tach_prescale.sv
`timescale 1ns/1ps
module tach_prescale #(
  parameter int PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] phase_q;

  assign tick_o = active_i && (phase_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                phase_q <= '0;
    else if (!active_i || tick_o) phase_q <= '0;
    else                        phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/tach_edge.sv
`timescale 1ns/1ps
module tach_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], pin_i};
  end

  assign rise_o = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/tach_channel.sv
`timescale 1ns/1ps
module tach_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             cmp_en_i,
  input  logic             pin_i,
  input  logic             run_wr_i,
  input  logic             run_val_i,
  input  logic             cnt_wr_i,
  input  logic             cap_wr_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             run_o,
  output logic             cap_evt_o,
  output logic             tmo_evt_o,
  output logic             unf_evt_o
);
  logic rise;
  logic done;

  tach_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .rise_o (rise)
  );

  // capture has priority over a timeout in the same cycle
  assign cap_evt_o = run_o && en_i && rise;
  assign tmo_evt_o = run_o && en_i && cmp_en_i && (cnt_o == cmp_o) && !rise;
  assign done      = cap_evt_o || tmo_evt_o;
  assign unf_evt_o = run_o && en_i && tick_i && (cnt_o == '0) && !done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o <= 1'b0;
      cnt_o <= '1;
      cap_o <= '1;
      cmp_o <= '0;
    end else begin
      if (done)          run_o <= 1'b0;
      else if (run_wr_i) run_o <= run_val_i;

      if (done)                  cnt_o <= cnt_o;
      else if (cnt_wr_i && !run_o) cnt_o <= wdata_i;
      else if (run_o && tick_i)  cnt_o <= cnt_o - 1'b1;

      if (cap_evt_o)     cap_o <= cnt_o;
      else if (cap_wr_i) cap_o <= wdata_i;

      if (cmp_wr_i)      cmp_o <= wdata_i;
    end
  end
endmodule

// File: rtl/tach_timer.sv
`timescale 1ns/1ps
module tach_timer
  import tach_pkg::*;
#(
  parameter int CW = tach_pkg::CNT_W,
  parameter int PW = tach_pkg::PRE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   wdata_i,
  output logic [15:0]   rdata_o,
  input  logic [NCH-1:0] tach_i,
  output logic          irq_o
);
  logic [PW-1:0]          pre_q;
  logic [7:0]             mode_q, ccfg_q;
  logic [NCH-1:0]         sel_q;
  logic [NPEND-1:0]       pend_q, ien_q, set_v, clr_v;
  logic [NCH-1:0]         run_v, cap_evt, tmo_evt, unf_evt;
  logic [NCH-1:0][CW-1:0] cnt_v, cap_v, cmp_v;
  logic                   tick;

  localparam logic [AW-1:0] CNT_OFS [NCH] = '{OFS_CNT_A, OFS_CNT_B};
  localparam logic [AW-1:0] CAP_OFS [NCH] = '{OFS_CAP_A, OFS_CAP_B};
  localparam logic [AW-1:0] CMP_OFS [NCH] = '{OFS_CMP_A, OFS_CMP_B};
  localparam logic [AW-1:0] SEL_OFS [NCH] = '{OFS_SEL_A, OFS_SEL_B};

  tach_prescale #(.PRE_W(PW)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (|run_v),
    .div_i    (pre_q),
    .tick_o   (tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tach_channel #(.CNT_W(CW)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick),
      .en_i      (mode_q[MODE_BIT[c]]),
      .cmp_en_i  (ccfg_q[CCFG_BIT[c]]),
      .pin_i     (sel_q[c] ? tach_i[NCH-1-c] : tach_i[c]),
      .run_wr_i  (we_i && addr_i == OFS_RUN),
      .run_val_i (wdata_i[RUN_BIT[c]]),
      .cnt_wr_i  (we_i && addr_i == CNT_OFS[c]),
      .cap_wr_i  (we_i && addr_i == CAP_OFS[c]),
      .cmp_wr_i  (we_i && addr_i == CMP_OFS[c]),
      .wdata_i   (wdata_i[CW-1:0]),
      .cnt_o     (cnt_v[c]),
      .cap_o     (cap_v[c]),
      .cmp_o     (cmp_v[c]),
      .run_o     (run_v[c]),
      .cap_evt_o (cap_evt[c]),
      .tmo_evt_o (tmo_evt[c]),
      .unf_evt_o (unf_evt[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             sel_q[c] <= 1'b0;
      else if (we_i && addr_i == SEL_OFS[c])   sel_q[c] <= wdata_i[0];
    end
  end

  // status bit order: capture A/B, wrap A/B, timeout A/B
  assign set_v = {tmo_evt[1], tmo_evt[0], unf_evt[1], unf_evt[0], cap_evt[1], cap_evt[0]};
  assign clr_v = (we_i && addr_i == OFS_CLR) ? wdata_i[NPEND-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      mode_q <= '0;
      ccfg_q <= '0;
      ien_q  <= '0;
      pend_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_v) | set_v;
      if (we_i) begin
        case (addr_i)
          OFS_PRE:  pre_q  <= wdata_i[PW-1:0];
          OFS_MODE: mode_q <= wdata_i[7:0];
          OFS_CCFG: ccfg_q <= wdata_i[7:0];
          OFS_IEN:  ien_q  <= wdata_i[NPEND-1:0];
          default: ;
        endcase
      end
    end
  end

  assign irq_o = |(pend_q & ien_q);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_CNT_A: rdata_o = 16'(cnt_v[0]);
      OFS_CAP_A: rdata_o = 16'(cap_v[0]);
      OFS_CAP_B: rdata_o = 16'(cap_v[1]);
      OFS_CNT_B: rdata_o = 16'(cnt_v[1]);
      OFS_PRE:   rdata_o = 16'(pre_q);
      OFS_RUN:   rdata_o = {12'b0, run_v[1], 2'b0, run_v[0]};
      OFS_MODE:  rdata_o = {8'b0, mode_q};
      OFS_STAT:  rdata_o = 16'(pend_q);
      OFS_IEN:   rdata_o = 16'(ien_q);
      OFS_CMP_A: rdata_o = 16'(cmp_v[0]);
      OFS_CMP_B: rdata_o = 16'(cmp_v[1]);
      OFS_CCFG:  rdata_o = {8'b0, ccfg_q};
      OFS_SEL_A: rdata_o = {15'b0, sel_q[0]};
      OFS_SEL_B: rdata_o = {15'b0, sel_q[1]};
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tach_timer_chk.sv
`timescale 1ns/1ps
module tach_timer_chk
  import tach_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [AW-1:0]    addr_i,
  input logic [15:0]      wdata_i,
  input logic             irq_o,
  input logic [NPEND-1:0] pend,
  input logic [NCH-1:0]   run,
  input logic             tick,
  input logic [NCH-1:0]   cap_evt,
  input logic [NCH-1:0]   tmo_evt,
  input logic [NPEND-1:0] set_v,
  input logic [CNT_W-1:0] cnt_a,
  input logic [CNT_W-1:0] cap_a
);
  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run[0] && tick && !cap_evt[0] && !tmo_evt[0] && cnt_a != '0
    |=> cnt_a == CNT_W'($past(cnt_a) - 1'b1));

  p_cap_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt[0] |=> (cap_a == cnt_a) && !run[0] && pend[0]);

  p_tmo_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_evt[0] |=> pend[4] && !run[0] && $stable(cnt_a));

  p_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run[0] && tick && cnt_a == '0 && !cap_evt[0] && !tmo_evt[0]
    |=> cnt_a == '1 && pend[2]);

  p_clear_all_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == OFS_CLR && wdata_i == 16'h003F && set_v == '0
    |=> pend == '0);

  p_irq_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend == '0 |-> !irq_o);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run[0] && !(we_i && addr_i == OFS_CNT_A) |=> $stable(cnt_a));
endmodule

bind tach_timer tach_timer_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .irq_o   (irq_o),
  .pend    (pend_q),
  .run     (run_v),
  .tick    (tick),
  .cap_evt (cap_evt),
  .tmo_evt (tmo_evt),
  .set_v   (set_v),
  .cnt_a   (cnt_v[0]),
  .cap_a   (cap_v[0])
);

// File: tb/sim_tach_timer.sv
`timescale 1ns/1ps
module sim_tach_timer;
  localparam logic [4:0] CNTA = 5'h00, CAPA = 5'h02, CAPB = 5'h04, CNTB = 5'h06;
  localparam logic [4:0] PRE = 5'h08, RUN = 5'h0A, MODE = 5'h0C, STAT = 5'h0E;
  localparam logic [4:0] CLR = 5'h10, IEN = 5'h12, CMPA = 5'h14, CMPB = 5'h16;
  localparam logic [4:0] CCFG = 5'h18, SELA = 5'h1A, SELB = 5'h1C;

  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [1:0]  tach = '0;
  logic        irq;
  int          nchk = 0, nfail = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  tach_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tach_i(tach), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic rdchk(input logic [4:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk); addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic irqchk(input logic exp, input string tag);
    @(negedge clk); #1;
    chk(tag, {15'b0, irq}, {15'b0, exp});
  endtask

  function automatic logic [15:0] exp_cap(input int j, input int p);
    return 16'hFFFF - 16'((j + 2) / (p + 1));
  endfunction

  // start channel ch, raise its pin between edges j and j+1 after the start edge
  task automatic cap_run(input int ch, input int p, input int j);
    wr(PRE, 16'(p));
    wr(ch ? CNTB : CNTA, 16'hFFFF);
    wr(CLR, 16'h003F);
    wr(RUN, ch ? 16'h0008 : 16'h0001);
    repeat (j) @(posedge clk);
    #1 tach[ch] = 1'b1;
    repeat (8) @(posedge clk);
    #1 tach[ch] = 1'b0;
  endtask

  initial begin
    #750000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rdchk(CNTA, 16'hFFFF, "R1 cnt A");
    rdchk(CAPA, 16'hFFFF, "R1 cap A");
    rdchk(CNTB, 16'hFFFF, "R1 cnt B");
    rdchk(CAPB, 16'hFFFF, "R1 cap B");
    rdchk(STAT, 16'h0000, "R1 status");
    rdchk(RUN,  16'h0000, "R1 run");
    rdchk(IEN,  16'h0000, "R1 ien");
    irqchk(1'b0, "R1 irq");

    // R2 register readback
    wr(CMPA, 16'h1234); rdchk(CMPA, 16'h1234, "R2 cmp A");
    wr(CMPB, 16'hBEEF); rdchk(CMPB, 16'hBEEF, "R2 cmp B");
    wr(PRE, 16'h00A5);  rdchk(PRE, 16'h00A5, "R2 prescaler");
    wr(SELB, 16'h0001); rdchk(SELB, 16'h0001, "R2 sel B");
    wr(SELB, 16'h0000);
    wr(MODE, 16'h0064); rdchk(MODE, 16'h0064, "R2 mode");
    wr(CCFG, 16'h0044); rdchk(CCFG, 16'h0044, "R2 ccfg");
    wr(IEN, 16'h003F);  rdchk(IEN, 16'h003F, "R2 ien");
    wr(CMPA, 16'h0000);

    // R3 count rate and stop
    wr(PRE, 16'd3); wr(CNTA, 16'hFFFF); wr(RUN, 16'h0001);
    repeat (40) @(posedge clk);
    rdchk(CNTA, 16'hFFF5, "R3 count after 40 cycles div4");
    wr(RUN, 16'h0000);
    rdchk(RUN, 16'h0000, "R3 stopped");
    repeat (10) @(posedge clk);
    rdchk(CNTA, 16'hFFF5, "R3 hold when stopped");

    // R10 write while running ignored, while stopped accepted
    wr(PRE, 16'd0); wr(CNTA, 16'hFFFF);
    wr(RUN, 16'h0001); wr(CNTA, 16'h1111); wr(RUN, 16'h0000);
    rdchk(CNTA, 16'hFFFD, "R10 write while running");
    wr(CNTA, 16'h1111);
    rdchk(CNTA, 16'h1111, "R10 write while stopped");

    // R4 directed corners and random captures
    cap_run(0, 0, 0);
    rdchk(CAPA, exp_cap(0, 0), "R4 cap j0 p0");
    rdchk(CNTA, exp_cap(0, 0), "R4 cnt equals cap");
    rdchk(STAT, 16'h0001, "R4 status A");
    rdchk(RUN, 16'h0000, "R4 run cleared");
    irqchk(1'b1, "R9 irq on capture");
    for (int i = 0; i < 12; i++) begin
      int p, j;
      p = $urandom_range(0, 5);
      j = $urandom_range(0, 50);
      cap_run(0, p, j);
      rdchk(CAPA, exp_cap(j, p), "R4 random cap");
      rdchk(CNTA, exp_cap(j, p), "R4 random cnt");
      rdchk(STAT, 16'h0001, "R4 random status");
    end

    // R5 timeout
    wr(CMPA, 16'hFFEB); wr(CAPA, 16'h5555);
    wr(PRE, 16'd0); wr(CNTA, 16'hFFFF); wr(CLR, 16'h003F); wr(RUN, 16'h0001);
    repeat (30) @(posedge clk);
    rdchk(STAT, 16'h0010, "R5 timeout flag");
    rdchk(CNTA, 16'hFFEB, "R5 counter at compare");
    rdchk(RUN,  16'h0000, "R5 run cleared");
    rdchk(CAPA, 16'h5555, "R5 capture untouched");

    // R6 capture and timeout in the same cycle
    cap_run(0, 0, 18);
    rdchk(STAT, 16'h0001, "R6 capture wins");
    rdchk(CAPA, 16'hFFEB, "R6 capture value");
    rdchk(RUN,  16'h0000, "R6 run cleared");

    // R7 wrap
    wr(CMPA, 16'h8000);
    wr(PRE, 16'd0); wr(CNTA, 16'h0005); wr(CLR, 16'h003F); wr(RUN, 16'h0001);
    repeat (10) @(posedge clk);
    rdchk(CNTA, 16'hFFFB, "R7 wrapped count");
    rdchk(STAT, 16'h0004, "R7 wrap flag");
    rdchk(RUN,  16'h0001, "R7 still running");
    wr(RUN, 16'h0000);

    // R9 enable masking
    irqchk(1'b1, "R9 irq wrap enabled");
    wr(IEN, 16'h003B); irqchk(1'b0, "R9 irq masked");
    wr(IEN, 16'h0004); irqchk(1'b1, "R9 irq single enable");

    // R8 write-one-to-clear
    wr(CLR, 16'h0001); rdchk(STAT, 16'h0004, "R8 zero bit keeps flag");
    wr(CLR, 16'h0004); rdchk(STAT, 16'h0000, "R8 one bit clears");
    irqchk(1'b0, "R9 irq after clear");
    wr(IEN, 16'h003F);

    // R11 mode disable
    wr(MODE, 16'h0020);
    cap_run(0, 0, 2);
    rdchk(STAT, 16'h0000, "R11 no event when disabled");
    rdchk(RUN,  16'h0001, "R11 still counting");
    wr(RUN, 16'h0000);
    wr(MODE, 16'h0064);

    // R12 channel B own pin, then A routed from pin 1
    cap_run(1, 0, 3);
    rdchk(CAPB, 16'hFFFA, "R12 cap B own pin");
    rdchk(CNTB, 16'hFFFA, "R12 cnt B");
    rdchk(STAT, 16'h0002, "R12 status B");
    wr(SELA, 16'h0001);
    wr(CNTA, 16'hFFFF); wr(CLR, 16'h003F); wr(RUN, 16'h0001);
    #1 tach[0] = 1'b1;
    repeat (6) @(posedge clk);
    rdchk(STAT, 16'h0000, "R12 own pin ignored when routed");
    rdchk(RUN,  16'h0001, "R12 A still running");
    #1 tach[0] = 1'b0; tach[1] = 1'b1;
    repeat (6) @(posedge clk);
    rdchk(STAT, 16'h0001, "R12 other pin captures");
    rdchk(RUN,  16'h0000, "R12 A stopped");
    #1 tach[1] = 1'b0;
    wr(SELA, 16'h0000);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule